// File: doc/BRIEF.md
# Integer ALU with instruction decode

This block takes one 32-bit instruction word together with the two source operand values and the address of the instruction. It decodes the word and computes the integer result. It handles two groups of instructions. The first is the register-register and register-immediate arithmetic, logic, shift and compare group. The second is the pair of upper-immediate instructions: load-upper and add-upper-to-address. The outputs are the result, the destination register index, a write enable and a flag for an unsupported encoding. The register file, memory access and control flow are handled elsewhere.

Transfers use a valid/ready handshake on each side, and a single register slice sits between them. An instruction is accepted on any clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` after that edge. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, a pending result and its flags stay unchanged, and no new instruction is taken.

Top module: `ix_alu_core`

## Requirements
- R1: Opcode 0x33 with funct3 000 adds when bits [31:25] are 0x00 and subtracts (rs1 minus rs2) when they are 0x20; both wrap modulo 2^32.
- R2: Opcode 0x13 with funct3 000 adds rs1 to the sign-extended immediate taken from bits [31:20], whatever bits [31:25] hold, so 0x20 there is just immediate bits and never selects subtract.
- R3: funct3 001 shifts left and funct3 101 shifts right (logical when bits [31:25] are 0x00, arithmetic when 0x20). The amount is the low 5 bits of rs2 on opcode 0x33 and bits [24:20] on opcode 0x13. Left and logical shifts fill with zeros, while the arithmetic shift copies the sign bit.
- R4: funct3 010 writes 1 when rs1 is less than the second operand as signed numbers, else 0. funct3 011 does the same with an unsigned compare. On opcode 0x13 the immediate is sign-extended first and then compared as unsigned.
- R5: funct3 100, 110 and 111 give XOR, OR and AND against rs2 (opcode 0x33) or against the sign-extended immediate (opcode 0x13).
- R6: Opcode 0x37 yields bits [31:12] of the instruction with the low 12 bits zero. Opcode 0x17 yields the instruction address plus that same value, wrapping modulo 2^32.
- R7: The write enable is low whenever the destination index (bits [11:7]) is 0, even though the result is still computed.
- R8: Any opcode other than 0x33, 0x13, 0x37 and 0x17 is unsupported. So is opcode 0x33 with bits [31:25] not 0x00, unless they are 0x20 on funct3 000 or 101. So is opcode 0x13 funct3 001 with bits [31:25] not 0x00, and opcode 0x13 funct3 101 with bits [31:25] neither 0x00 nor 0x20. An unsupported word raises the illegal flag, lowers the write enable and gives a zero result.
- R9: `in_ready` equals `!out_valid || out_ready`. An accepted instruction's outputs appear with `out_valid` high in the cycle after the accepting edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_rd`, `out_wen` and `out_illegal` stay unchanged.
- R11: During and right after reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Block can take an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| in_rs1_val | input | XLEN | First source operand value |
| in_rs2_val | input | XLEN | Second source operand value |
| in_pc | input | XLEN | Address of the instruction |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | XLEN | Computed value |
| out_rd | output | IDX_W | Destination register index |
| out_wen | output | 1 | Result should be written back |
| out_illegal | output | 1 | Instruction word is not supported |

## Verification
The bench builds the block at its default widths: a 32-bit datapath and a 5-bit register index. At these widths every shift amount from 0 to 31 can be reached, and so can the wrap of sums and address offsets at 2^32. The 5-bit index also makes destination index zero a frequent case under random fields. Random words mix legal and illegal values in bits [31:25], which reaches every legality rule of the decoder. A directed stall sequence holds the consumer off across several cycles.

// File: rtl/ix_alu_pkg.sv
package ix_alu_pkg;

  localparam int ILEN = 32;

  localparam logic [6:0] OPC_REG   = 7'h33;
  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_LUI   = 7'h37;
  localparam logic [6:0] OPC_AUIPC = 7'h17;

  localparam logic [6:0] F7_BASE = 7'h00;
  localparam logic [6:0] F7_ALT  = 7'h20;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SLL, K_SLT, K_SLTU, K_XOR, K_SRL, K_SRA, K_OR, K_AND
  } kind_e;

  typedef enum logic [1:0] {
    SA_RS1, SA_PC, SA_ZERO
  } srca_e;

  typedef struct packed {
    kind_e kind;
    srca_e srca;
    logic  use_imm;
    logic  wen;
    logic  illegal;
  } ctl_t;

  // funct3 to operation; alt picks the second member of a shared code
  function automatic kind_e kind_of(input logic [2:0] f3, input logic alt);
    kind_e k;
    case (f3)
      3'b000:  k = alt ? K_SUB : K_ADD;
      3'b001:  k = K_SLL;
      3'b010:  k = K_SLT;
      3'b011:  k = K_SLTU;
      3'b100:  k = K_XOR;
      3'b101:  k = alt ? K_SRA : K_SRL;
      3'b110:  k = K_OR;
      default: k = K_AND;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ix_alu_decode.sv
module ix_alu_decode
  import ix_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic [ILEN-1:0]  instr,
  output ctl_t             ctl,
  output logic [XLEN-1:0]  imm,
  output logic [IDX_W-1:0] rd
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       f7_base;
  logic       f7_alt;
  logic [XLEN-1:0] imm_i;
  logic [XLEN-1:0] imm_u;

  assign opc     = instr[6:0];
  assign f3      = instr[14:12];
  assign f7      = instr[31:25];
  assign f7_base = (f7 == F7_BASE);
  assign f7_alt  = (f7 == F7_ALT);
  assign rd      = instr[7 +: IDX_W];

  assign imm_i = XLEN'($signed(instr[31:20]));
  assign imm_u = XLEN'($signed({instr[31:12], 12'h000}));

  always_comb begin
    ctl.kind    = K_ADD;
    ctl.srca    = SA_RS1;
    ctl.use_imm = 1'b0;
    ctl.illegal = 1'b0;
    imm         = imm_i;
    case (opc)
      OPC_REG: begin
        ctl.kind = kind_of(f3, f7_alt);
        if (f3 == 3'b000 || f3 == 3'b101)
          ctl.illegal = !(f7_base || f7_alt);
        else
          ctl.illegal = !f7_base;
      end
      OPC_IMM: begin
        ctl.use_imm = 1'b1;
        // upper immediate bits only qualify the shift codes
        ctl.kind = kind_of(f3, (f3 == 3'b101) && f7_alt);
        if (f3 == 3'b001)
          ctl.illegal = !f7_base;
        else if (f3 == 3'b101)
          ctl.illegal = !(f7_base || f7_alt);
      end
      OPC_LUI: begin
        ctl.srca    = SA_ZERO;
        ctl.use_imm = 1'b1;
        imm         = imm_u;
      end
      OPC_AUIPC: begin
        ctl.srca    = SA_PC;
        ctl.use_imm = 1'b1;
        imm         = imm_u;
      end
      default: ctl.illegal = 1'b1;
    endcase
    ctl.wen = !ctl.illegal && (rd != '0);
  end

endmodule

// File: rtl/ix_alu_exec.sv
module ix_alu_exec
  import ix_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  kind_e           kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0] sh;
  logic           lt_s;
  logic           lt_u;

  assign sh   = b[SHW-1:0];
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    case (kind)
      K_ADD:   y = a + b;
      K_SUB:   y = a - b;
      K_SLL:   y = a << sh;
      K_SRL:   y = a >> sh;
      K_SRA:   y = $unsigned($signed(a) >>> sh);
      K_SLT:   y = {{(XLEN-1){1'b0}}, lt_s};
      K_SLTU:  y = {{(XLEN-1){1'b0}}, lt_u};
      K_XOR:   y = a ^ b;
      K_OR:    y = a | b;
      K_AND:   y = a & b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/ix_alu_outreg.sv
module ix_alu_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/ix_alu_core.sv
module ix_alu_core
  import ix_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_instr,
  input  logic [XLEN-1:0]  in_rs1_val,
  input  logic [XLEN-1:0]  in_rs2_val,
  input  logic [XLEN-1:0]  in_pc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic [IDX_W-1:0] out_rd,
  output logic             out_wen,
  output logic             out_illegal
);

  localparam int PW = XLEN + IDX_W + 2;

  ctl_t             ctl;
  logic [XLEN-1:0]  imm;
  logic [IDX_W-1:0] rd;
  logic [XLEN-1:0]  op_a;
  logic [XLEN-1:0]  op_b;
  logic [XLEN-1:0]  y;
  logic [XLEN-1:0]  result;
  logic [PW-1:0]    pay_in;
  logic [PW-1:0]    pay_out;

  ix_alu_decode #(.XLEN(XLEN), .IDX_W(IDX_W)) u_dec (
    .instr (in_instr),
    .ctl   (ctl),
    .imm   (imm),
    .rd    (rd)
  );

  always_comb begin
    case (ctl.srca)
      SA_PC:   op_a = in_pc;
      SA_ZERO: op_a = '0;
      default: op_a = in_rs1_val;
    endcase
  end

  assign op_b = ctl.use_imm ? imm : in_rs2_val;

  ix_alu_exec #(.XLEN(XLEN)) u_exec (
    .kind (ctl.kind),
    .a    (op_a),
    .b    (op_b),
    .y    (y)
  );

  assign result = ctl.illegal ? '0 : y;
  assign pay_in = {result, rd, ctl.wen, ctl.illegal};

  ix_alu_outreg #(.W(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_result, out_rd, out_wen, out_illegal} = pay_out;

endmodule

// File: rtl/ix_alu_chk.sv
module ix_alu_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [31:0]      in_instr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  out_result,
  input logic [IDX_W-1:0] out_rd,
  input logic             out_wen,
  input logic             out_illegal
);

  p_lui_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[6:0] == 7'h37) |=> (out_valid && out_result[11:0] == 12'h000));

  p_no_x0_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_wen && out_rd == '0));

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_wen && out_result == '0));

  p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_valid_from_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_rd)
                                   && $stable(out_wen) && $stable(out_illegal)));

endmodule

bind ix_alu_core ix_alu_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_instr    (in_instr),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_rd      (out_rd),
  .out_wen     (out_wen),
  .out_illegal (out_illegal)
);

// File: tb/tb_ix_alu_core.sv
module tb_ix_alu_core;

  typedef struct packed {
    logic [31:0] res;
    logic        wen;
    logic        ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rs1_val = '0;
  logic [31:0] in_rs2_val = '0;
  logic [31:0] in_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [4:0]  out_rd;
  logic        out_wen;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ix_alu_core dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] calc(input logic [2:0] f3, input bit alt,
                                       input logic [31:0] a, input logic [31:0] b);
    case (f3)
      3'd0: return alt ? a - b : a + b;
      3'd1: return a << b[4:0];
      3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      3'd4: return a ^ b;
      3'd5: return alt ? $unsigned($signed(a) >>> b[4:0]) : a >> b[4:0];
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] ins, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] pc);
    exp_t e;
    logic [6:0] op = ins[6:0];
    logic [2:0] f3 = ins[14:12];
    logic [6:0] f7 = ins[31:25];
    logic [31:0] ii = {{20{ins[31]}}, ins[31:20]};
    logic [31:0] iu = {ins[31:12], 12'h000};
    e = '0;
    if (op == 7'h33) begin
      if (f7 == 7'h00 || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5)))
        e.res = calc(f3, f7 == 7'h20, a, b);
      else e.ill = 1'b1;
    end else if (op == 7'h13) begin
      if (f3 == 3'd1 && f7 != 7'h00) e.ill = 1'b1;
      else if (f3 == 3'd5 && f7 != 7'h00 && f7 != 7'h20) e.ill = 1'b1;
      else e.res = calc(f3, f3 == 3'd5 && f7 == 7'h20, a, ii);
    end else if (op == 7'h37) e.res = iu;
    else if (op == 7'h17) e.res = pc + iu;
    else e.ill = 1'b1;
    e.wen = !e.ill && ins[11:7] != 5'd0;
    return e;
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    exp_t e = model(ins, 0, 0, 0);
    if (e.ill) return "R8";
    if (ins[6:0] == 7'h37 || ins[6:0] == 7'h17) return "R6";
    case (ins[14:12])
      3'd0: return (ins[6:0] == 7'h13) ? "R2" : "R1";
      3'd1, 3'd5: return "R3";
      3'd2, 3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, 5'd3, 5'd2, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [2:0] f3, input logic [4:0] rd);
    return {im, 5'd2, f3, rd, 7'h13};
  endfunction
  function automatic logic [31:0] enc_u(input logic [19:0] im, input logic [4:0] rd, input logic [6:0] op);
    return {im, rd, op};
  endfunction

  // one accepted instruction, checked at the negedge after the capture edge
  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] pc, input string req);
    exp_t e = model(ins, a, b, pc);
    @(negedge clk);
    in_instr = ins; in_rs1_val = a; in_rs2_val = b; in_pc = pc;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == e.res, req, {31'd0, out_valid, out_result}, {32'd1, e.res});
    check(out_wen == e.wen && out_illegal == e.ill && out_rd == ins[11:7], req,
          {57'd0, out_rd, out_wen, out_illegal}, {57'd0, ins[11:7], e.wen, e.ill});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R11 reset", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R11 after reset", {62'd0, out_valid, in_ready}, 64'd1);

    issue(enc_r(7'h00, 3'd0, 5'd1), 32'hFFFF_FFFF, 32'd2, 0, "R1 add wrap");
    issue(enc_r(7'h20, 3'd0, 5'd1), 32'd0, 32'd1, 0, "R1 sub wrap");
    issue(enc_i(12'h400, 3'd0, 5'd4), 32'd5, 32'd99, 0, "R2 addi alt bits");
    issue(enc_i(12'hFFF, 3'd0, 5'd4), 32'd0, 32'd0, 0, "R2 addi negative");
    issue(enc_r(7'h00, 3'd1, 5'd5), 32'd3, 32'h21, 0, "R3 sll masks amount");
    issue(enc_r(7'h20, 3'd5, 5'd5), 32'h8000_0000, 32'd4, 0, "R3 sra");
    issue(enc_r(7'h00, 3'd5, 5'd5), 32'h8000_0000, 32'd4, 0, "R3 srl");
    issue(enc_i({7'h20, 5'd31}, 3'd5, 5'd6), 32'h8000_0000, 32'd0, 0, "R3 srai 31");
    issue(enc_i({7'h00, 5'd31}, 3'd1, 5'd6), 32'd1, 32'd0, 0, "R3 slli 31");
    issue(enc_r(7'h00, 3'd2, 5'd7), 32'hFFFF_FFFF, 32'd1, 0, "R4 slt signed");
    issue(enc_r(7'h00, 3'd3, 5'd7), 32'hFFFF_FFFF, 32'd1, 0, "R4 sltu");
    issue(enc_r(7'h00, 3'd3, 5'd7), 32'd0, 32'd5, 0, "R4 sltu zero");
    issue(enc_i(12'hFFF, 3'd3, 5'd7), 32'd5, 32'd0, 0, "R4 sltiu sext");
    issue(enc_i(12'hFFF, 3'd2, 5'd7), 32'd0, 32'd0, 0, "R4 slti");
    issue(enc_i(12'hFFF, 3'd4, 5'd8), 32'h1234_5678, 32'd0, 0, "R5 xori not");
    issue(enc_r(7'h00, 3'd6, 5'd8), 32'hF0F0_0000, 32'h0000_0F0F, 0, "R5 or");
    issue(enc_i(12'h0F0, 3'd7, 5'd8), 32'hFFFF_FFFF, 32'd0, 0, "R5 andi");
    issue(enc_u(20'hDEADB, 5'd9, 7'h37), 32'h1111_1111, 32'd0, 32'h40, "R6 lui");
    issue(enc_u(20'h00001, 5'd9, 7'h17), 32'd0, 32'd0, 32'h1000, "R6 auipc");
    issue(enc_u(20'hFFFFF, 5'd9, 7'h17), 32'd0, 32'd0, 32'h2000, "R6 auipc wrap");
    issue(enc_r(7'h00, 3'd0, 5'd0), 32'd7, 32'd8, 0, "R7 rd zero");
    issue(enc_u(20'hABCDE, 5'd0, 7'h37), 32'd0, 32'd0, 0, "R7 lui rd zero");
    issue({12'h004, 5'd2, 3'd2, 5'd3, 7'h03}, 32'd1, 32'd1, 0, "R8 load opcode");
    issue(enc_r(7'h01, 3'd0, 5'd3), 32'd1, 32'd1, 0, "R8 bad funct7");
    issue(enc_r(7'h20, 3'd2, 5'd3), 32'd1, 32'd1, 0, "R8 alt on slt");
    issue(enc_i({7'h20, 5'd1}, 3'd1, 5'd3), 32'd1, 32'd1, 0, "R8 slli alt");
    issue(enc_i({7'h10, 5'd1}, 3'd5, 5'd3), 32'd1, 32'd1, 0, "R8 shift-right bad");

    // back-pressure
    begin
      exp_t ea = model(enc_r(7'h00, 3'd0, 5'd10), 32'd10, 32'd20, 0);
      exp_t eb = model(enc_r(7'h20, 3'd0, 5'd11), 32'd10, 32'd20, 0);
      @(negedge clk);
      out_ready = 1'b0;
      in_instr = enc_r(7'h00, 3'd0, 5'd10); in_rs1_val = 32'd10; in_rs2_val = 32'd20;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_instr = enc_r(7'h20, 3'd0, 5'd11);
      check(out_valid && !in_ready && out_result == ea.res, "R9 stall ready low",
            {30'd0, out_valid, in_ready, out_result}, {32'h2, ea.res});
      repeat (2) begin
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_result == ea.res && out_rd == 5'd10, "R10 held",
              {27'd0, out_rd, out_result}, {27'd0, 5'd10, ea.res});
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && out_result == eb.res && out_rd == 5'd11, "R9 drain then take",
            {27'd0, out_rd, out_result}, {27'd0, 5'd11, eb.res});
      @(posedge clk);
      @(negedge clk);
      check(!out_valid, "R9 idle empties", {63'd0, out_valid}, 64'd0);
    end

    for (int i = 0; i < 400; i++) begin
      logic [6:0] op;
      logic [6:0] f7;
      logic [31:0] ins;
      case ($urandom % 7)
        0, 1: op = 7'h33;
        2, 3: op = 7'h13;
        4: op = 7'h37;
        5: op = 7'h17;
        default: op = 7'($urandom);
      endcase
      case ($urandom % 3)
        0: f7 = 7'h00;
        1: f7 = 7'h20;
        default: f7 = 7'($urandom);
      endcase
      ins = {f7, 25'($urandom)};
      ins[6:0] = op;
      issue(ins, $urandom, $urandom, $urandom, tag_of(ins));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule